// File: doc/BRIEF.md
# Debug Address-Translation Probe Port

This block gives software a way to ask the address-translation engine of an I/O memory management unit what a single I/O virtual address maps to, for a chosen device and process, without sending real DMA traffic. Software loads the virtual address into one 64-bit register. It then writes a second 64-bit register that carries the device identifier, the process identifier and a go flag. The port sends one request to an external engine that looks up the context and translates the address, then packs the engine's answer into a third 64-bit register.

A single flag bit in the control register does two jobs. Software sets it to launch a request, and the hardware clears it when the response is ready, so software polls that bit to see when the request is done. The response holds either a physical page number or a fault flag with an 11-bit cause code. A request for which the engine finds no context always returns the DMA-disabled cause, whatever else the engine's reply carries. The port has no enable control, and a constant output reports that the debug capability is present.

Top module: `xprobe_port`

## Requirements
- R1: After reset the address, control and response registers read as zero, and `eng_req_valid` is low.
- R2: Offset 0x258 is the request-address register, read/write, 64 bits. Offset 0x260 is the control register, with the go/busy flag in bit 0, the process identifier in bits 31:12 and the device identifier in bits 63:40. Its other bits read as zero.
- R3: While the port is idle, a write to 0x260 with bit 0 set sets busy and raises exactly one engine request carrying the stored address, device identifier and process identifier. `eng_req_valid` and the request fields stay steady until `eng_req_ready`.
- R4: A write to 0x260 with bit 0 clear starts nothing and leaves both the control register and the response register unchanged.
- R5: When the engine reply arrives, the response register is updated and bit 0 of the control register clears at the same clock edge.
- R6: If the reply reports that no context was found, the response is bit 0 set with cause 256 in bits 20:10 (value 0x40001). The reply's fault, cause and page fields are ignored.
- R7: If the reply reports a translation fault, the response is bit 0 set with the 11-bit reply cause in bits 20:10, and all other bits are zero.
- R8: On success the response has bit 0 clear, the 44-bit page number in bits 53:10, and all other bits zero.
- R9: While busy is set, writes to 0x258 and 0x260 are ignored, including a write that arrives in the same cycle as the reply.
- R10: `cap_probe_present` is always 1.
- R11: The response register at 0x268 is read-only, so writes to it have no effect.
- R12: Reads of any offset other than the three registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` (combinational) |
| cap_probe_present | output | 1 | Debug capability indicator, always 1 |
| eng_req_valid | output | 1 | Translation request valid |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_addr | output | 64 | I/O virtual address to translate |
| eng_req_dev | output | 24 | Device identifier |
| eng_req_proc | output | 20 | Process identifier |
| eng_rsp_valid | input | 1 | Engine reply valid (one cycle) |
| eng_rsp_ctx_ok | input | 1 | A context exists for the device/process pair |
| eng_rsp_fault | input | 1 | Translation faulted |
| eng_rsp_cause | input | 11 | Fault cause code |
| eng_rsp_ppn | input | 44 | Translated physical page number |

## Verification
The engine's reply and a new software write to the control register can land in the same cycle. In that cycle completion must win: the write is dropped because busy is still set. The bench provokes this by driving a go write with a different device identifier on the exact edge where its engine model raises the reply. It then checks three things: the response matches the first request, the control register still holds the first device identifier with busy clear, and the engine model saw no second request. Outside that case, a sweep over device identifiers and page indices covers the missing-context, fault and success outcomes, with varied ready and reply delays.

// File: rtl/xprobe_pkg.sv
package xprobe_pkg;

    localparam int REG_W    = 64;
    localparam int OFF_W    = 12;
    localparam int DEV_W    = 24;
    localparam int PROC_W   = 20;
    localparam int CAUSE_W  = 11;
    localparam int PPN_W    = 44;
    localparam int PROC_LSB = 12;
    localparam int DEV_LSB  = REG_W - DEV_W;
    localparam int CODE_LSB = 10;
    localparam int GAP_HI_W = DEV_LSB - (PROC_LSB + PROC_W);
    localparam int GAP_LO_W = PROC_LSB - 1;

    localparam logic [OFF_W-1:0] OFF_ADDR = 12'h258;
    localparam logic [OFF_W-1:0] OFF_CTL  = 12'h260;
    localparam logic [OFF_W-1:0] OFF_RSP  = 12'h268;

    localparam logic [CAUSE_W-1:0] CAUSE_NO_CTX = 11'd256;

    typedef struct packed {
        logic [REG_W-1:0]  iova;
        logic [DEV_W-1:0]  dev_id;
        logic [PROC_W-1:0] proc_id;
    } xreq_t;

    typedef struct packed {
        logic               ctx_ok;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        logic [PPN_W-1:0]   ppn;
    } xrsp_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } xstate_t;

    function automatic logic [REG_W-1:0] pack_fault(input logic [CAUSE_W-1:0] cause);
        logic [REG_W-1:0] w;
        w = '0;
        w[0] = 1'b1;
        w[CODE_LSB +: CAUSE_W] = cause;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_page(input logic [PPN_W-1:0] ppn);
        logic [REG_W-1:0] w;
        w = '0;
        w[CODE_LSB +: PPN_W] = ppn;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] ctl_view(input xreq_t r, input logic busy);
        return {r.dev_id, {GAP_HI_W{1'b0}}, r.proc_id, {GAP_LO_W{1'b0}}, busy};
    endfunction

endpackage

// File: rtl/xprobe_fmt.sv
module xprobe_fmt
    import xprobe_pkg::*;
(
    input  xrsp_t            rsp,
    output logic [REG_W-1:0] word
);

    always_comb begin
        if (!rsp.ctx_ok) begin
            word = pack_fault(CAUSE_NO_CTX);
        end else if (rsp.fault) begin
            word = pack_fault(rsp.cause);
        end else begin
            word = pack_page(rsp.ppn);
        end
    end

endmodule

// File: rtl/xprobe_regs.sv
module xprobe_regs
    import xprobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [OFF_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             done,
    input  logic [REG_W-1:0] rsp_word,
    output logic             start,
    output logic             busy,
    output xreq_t            req
);

    xreq_t            req_q;
    logic             busy_q;
    logic [REG_W-1:0] rsp_q;
    logic             wr_addr;
    logic             wr_go;
    logic             unused_wbits;

    assign wr_addr = bus_we && (bus_addr == OFF_ADDR) && !busy_q;
    assign wr_go   = bus_we && (bus_addr == OFF_CTL) && !busy_q && bus_wdata[0];
    assign unused_wbits = ^{bus_wdata[DEV_LSB-1 -: GAP_HI_W], bus_wdata[GAP_LO_W:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            busy_q <= 1'b0;
            rsp_q  <= '0;
        end else begin
            if (wr_addr) begin
                req_q.iova <= bus_wdata;
            end
            if (wr_go) begin
                req_q.dev_id  <= bus_wdata[DEV_LSB +: DEV_W];
                req_q.proc_id <= bus_wdata[PROC_LSB +: PROC_W];
                busy_q        <= 1'b1;
            end else if (done) begin
                busy_q <= 1'b0;
            end
            if (done) begin
                rsp_q <= rsp_word;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFF_ADDR: bus_rdata = req_q.iova;
            OFF_CTL:  bus_rdata = ctl_view(req_q, busy_q);
            OFF_RSP:  bus_rdata = rsp_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign start = wr_go;
    assign busy  = busy_q;
    assign req   = req_q;

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(req_q)); // R9

    AST_RSP_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_q |=> $stable(rsp_q)); // R4

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q); // R5

    AST_FAULT_FMT: assert property (@(posedge clk) disable iff (rst)
        rsp_q[0] |-> (rsp_q[REG_W-1:CODE_LSB+CAUSE_W] == '0) && (rsp_q[CODE_LSB-1:1] == '0)); // R7

    AST_PAGE_FMT: assert property (@(posedge clk) disable iff (rst)
        !rsp_q[0] |-> (rsp_q[CODE_LSB-1:0] == '0) && (rsp_q[REG_W-1:CODE_LSB+PPN_W] == '0)); // R8

endmodule

// File: rtl/xprobe_seq.sv
module xprobe_seq
    import xprobe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic req_valid,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic done
);

    xstate_t state_q;
    xstate_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_valid = (state_q == ST_ISSUE);
    assign done      = (state_q == ST_WAIT) && rsp_valid;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid); // R3

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> state_q == ST_IDLE); // R3

endmodule

// File: rtl/xprobe_port.sv
module xprobe_port
    import xprobe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [OFF_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic               cap_probe_present,
    output logic               eng_req_valid,
    input  logic               eng_req_ready,
    output logic [REG_W-1:0]   eng_req_addr,
    output logic [DEV_W-1:0]   eng_req_dev,
    output logic [PROC_W-1:0]  eng_req_proc,
    input  logic               eng_rsp_valid,
    input  logic               eng_rsp_ctx_ok,
    input  logic               eng_rsp_fault,
    input  logic [CAUSE_W-1:0] eng_rsp_cause,
    input  logic [PPN_W-1:0]   eng_rsp_ppn
);

    logic             start;
    logic             busy;
    logic             done;
    xreq_t            req;
    xrsp_t            rsp;
    logic [REG_W-1:0] rsp_word;

    assign rsp = '{ctx_ok: eng_rsp_ctx_ok, fault: eng_rsp_fault,
                   cause: eng_rsp_cause, ppn: eng_rsp_ppn};

    xprobe_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done),
        .rsp_word  (rsp_word),
        .start     (start),
        .busy      (busy),
        .req       (req)
    );

    xprobe_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_valid (eng_req_valid),
        .req_ready (eng_req_ready),
        .rsp_valid (eng_rsp_valid),
        .done      (done)
    );

    xprobe_fmt u_fmt (
        .rsp  (rsp),
        .word (rsp_word)
    );

    assign eng_req_addr      = req.iova;
    assign eng_req_dev       = req.dev_id;
    assign eng_req_proc      = req.proc_id;
    assign cap_probe_present = 1'b1;

    AST_NOCTX_CODE: assert property (@(posedge clk) disable iff (rst)
        done && !eng_rsp_ctx_ok |-> rsp_word == 64'h40001); // R6

    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_req_valid |-> busy); // R3

endmodule

// File: tb/xprobe_port_tb.sv
module xprobe_port_tb;

    localparam logic [11:0] A_ADDR = 12'h258;
    localparam logic [11:0] A_CTL  = 12'h260;
    localparam logic [11:0] A_RSP  = 12'h268;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        cap_probe_present;
    logic        eng_req_valid;
    logic        eng_req_ready = 1'b0;
    logic [63:0] eng_req_addr;
    logic [23:0] eng_req_dev;
    logic [19:0] eng_req_proc;
    logic        eng_rsp_valid = 1'b0;
    logic        eng_rsp_ctx_ok = 1'b0;
    logic        eng_rsp_fault = 1'b0;
    logic [10:0] eng_rsp_cause = '0;
    logic [43:0] eng_rsp_ppn = '0;

    int checks = 0;
    int fails = 0;
    int req_count = 0;
    int ready_dly = 0;
    int rsp_dly = 0;
    logic [63:0] seen_addr;
    logic [23:0] seen_dev;
    logic [19:0] seen_proc;

    always #2 clk = ~clk;

    xprobe_port u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_probe_present(cap_probe_present),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_req_addr(eng_req_addr), .eng_req_dev(eng_req_dev),
        .eng_req_proc(eng_req_proc), .eng_rsp_valid(eng_rsp_valid),
        .eng_rsp_ctx_ok(eng_rsp_ctx_ok), .eng_rsp_fault(eng_rsp_fault),
        .eng_rsp_cause(eng_rsp_cause), .eng_rsp_ppn(eng_rsp_ppn)
    );

    function automatic logic [43:0] mk_ppn(int dev, int page);
        return 44'h800000000 + 44'(dev * 4096 + page * 17);
    endfunction

    function automatic logic [10:0] mk_cause(int dev, int page);
        return 11'(page * 16 + dev + 1);
    endfunction

    function automatic logic [63:0] expect_rsp(int dev, int page);
        if (dev % 3 == 0) return 64'h1 | (64'd256 << 10);
        if (page == 5)    return 64'h1 | (64'(mk_cause(dev, page)) << 10);
        return 64'(mk_ppn(dev, page)) << 10;
    endfunction

    function automatic logic [63:0] mk_addr(int dev, int page);
        return (64'(dev) << 32) | (64'(page) << 12) | 64'habc;
    endfunction

    function automatic logic [63:0] mk_ctl(int dev, int proc, logic go);
        return (64'(dev) << 40) | (64'(proc) << 12) | 64'(go);
    endfunction

    // engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req_valid) begin
                repeat (ready_dly) @(negedge clk);
                seen_addr = eng_req_addr;
                seen_dev  = eng_req_dev;
                seen_proc = eng_req_proc;
                eng_req_ready = 1'b1;
                @(negedge clk);
                eng_req_ready = 1'b0;
                req_count++;
                repeat (rsp_dly) @(negedge clk);
                begin
                    int d, p;
                    d = int'(seen_dev);
                    p = int'(seen_addr[14:12]);
                    if (d % 3 == 0) begin
                        eng_rsp_ctx_ok = 1'b0;
                        eng_rsp_fault  = p[0];
                        eng_rsp_cause  = 11'h7ff;
                        eng_rsp_ppn    = '1;
                    end else begin
                        eng_rsp_ctx_ok = 1'b1;
                        eng_rsp_fault  = (p == 5);
                        eng_rsp_cause  = mk_cause(d, p);
                        eng_rsp_ppn    = mk_ppn(d, p);
                    end
                end
                eng_rsp_valid = 1'b1;
                @(negedge clk);
                eng_rsp_valid = 1'b0;
            end
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(A_CTL, v);
            if (!v[0]) break;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_ADDR, v); check("R1 addr reset", v, 64'h0);
        rd(A_CTL, v);  check("R1 ctl reset", v, 64'h0);
        rd(A_RSP, v);  check("R1 rsp reset", v, 64'h0);
        check("R1 req_valid reset", 64'(eng_req_valid), 64'h0);
        check("R10 capability", 64'(cap_probe_present), 64'h1);

        // R12 unmapped
        rd(12'h250, v); check("R12 unmapped 0x250", v, 64'h0);
        rd(12'h270, v); check("R12 unmapped 0x270", v, 64'h0);

        // R2 address register readback
        wr(A_ADDR, 64'hfedc_ba98_7654_3210);
        rd(A_ADDR, v); check("R2 addr readback", v, 64'hfedc_ba98_7654_3210);

        // R4 write with go clear: no request, ctl and rsp unchanged
        base = req_count;
        wr(A_CTL, 64'hffff_ffff_ffff_fffe);
        repeat (4) @(negedge clk);
        rd(A_CTL, v); check("R4 ctl unchanged", v, 64'h0);
        rd(A_RSP, v); check("R4 rsp unchanged", v, 64'h0);
        check("R4 no request", 64'(req_count), 64'(base));

        // R3/R5..R8 sweep
        for (int d = 0; d < 6; d++) begin
            for (int p = 0; p < 8; p++) begin
                int pid;
                pid = d * 7 + p + 1;
                ready_dly = p % 3;
                rsp_dly = d % 2;
                base = req_count;
                wr(A_ADDR, mk_addr(d, p));
                wr(A_CTL, mk_ctl(d, pid, 1'b1) | 64'h0000_00ff_0000_0ffe);
                wait_idle();
                rd(A_RSP, v);
                if (d % 3 == 0)  check("R6 no-context response", v, expect_rsp(d, p));
                else if (p == 5) check("R7 fault response", v, expect_rsp(d, p));
                else             check("R8 page response", v, expect_rsp(d, p));
                check("R3 request fields", {seen_addr ^ 64'(seen_proc), 40'(seen_dev)},
                      {mk_addr(d, p) ^ 64'(pid), 40'(d)});
                check("R3 one request", 64'(req_count - base), 64'd1);
                rd(A_CTL, v); check("R2 R5 ctl after done", v, mk_ctl(d, pid, 1'b0));
            end
        end

        // R11 response read-only
        rd(A_RSP, v);
        wr(A_RSP, ~v);
        begin
            logic [63:0] v2;
            rd(A_RSP, v2); check("R11 rsp write ignored", v2, v);
        end

        // R9 writes while busy ignored
        ready_dly = 0; rsp_dly = 8;
        base = req_count;
        wr(A_ADDR, mk_addr(4, 2));
        wr(A_CTL, mk_ctl(4, 99, 1'b1));
        wr(A_ADDR, mk_addr(1, 6));
        wr(A_CTL, mk_ctl(2, 5, 1'b1));
        wait_idle();
        rd(A_ADDR, v); check("R9 addr write while busy", v, mk_addr(4, 2));
        rd(A_RSP, v);  check("R9 rsp from first request", v, expect_rsp(4, 2));
        rd(A_CTL, v);  check("R9 ctl write while busy", v, mk_ctl(4, 99, 1'b0));
        check("R9 single request", 64'(req_count - base), 64'd1);

        // R9/R5 collision: go write in the reply cycle
        ready_dly = 1; rsp_dly = 3;
        base = req_count;
        wr(A_ADDR, mk_addr(5, 3));
        wr(A_CTL, mk_ctl(5, 42, 1'b1));
        @(posedge eng_rsp_valid);
        bus_we = 1'b1; bus_addr = A_CTL; bus_wdata = mk_ctl(1, 7, 1'b1);
        @(negedge clk);
        bus_we = 1'b0;
        repeat (6) @(negedge clk);
        rd(A_CTL, v); check("R9 collision ctl", v, mk_ctl(5, 42, 1'b0));
        rd(A_RSP, v); check("R5 collision rsp", v, expect_rsp(5, 3));
        check("R9 collision no second request", 64'(req_count - base), 64'd1);
        check("R10 capability final", 64'(cap_probe_present), 64'h1);

        finish_run();
    end

endmodule